// File: doc/BRIEF.md
# Host Bus Address Latch and Decoder

This block is the front end of an I/O-mapped peripheral that sits on an asynchronous host bus. When the bus address strobe rises, the block captures three things together: the word address, the DMA qualifier and the four active-low byte enables. The strobe is sampled in the peripheral's clock domain, and the capture happens on the first clock edge that sees the strobe high after it was low.

The block compares the upper address bits it has captured with a 12-bit base register. Software loads that register through a synchronous write port. The result of the comparison is an active-low device select and a three-bit register offset.

The byte enables are turned into an access-kind code and a four-bit lane mask. A central chip-select input can override the byte enables and force a full-width data-register access. A mode pin chooses the bus width. In narrow (16-bit) mode the upper two lanes do not exist, and the central chip select is ignored.

There is no data stream through this block, so it has no valid/ready interface. Every pin is a plain level, and it is meaningful while the captured state stays constant between strobes.

Top module: `hb_addr_decode`

## Requirements
- R1: On the first `clk` rising edge at which `bus_stb` is 1 and was 0 at the previous edge, the block captures `bus_addr`, `bus_dma`, `bus_be_n` and `wide_mode`. All outputs that derive from these values show the new values after that edge.
- R2: The captured state does not change between captures, whatever happens on the bus inputs. The active-low asynchronous reset `rst_n` clears it. After reset `ldev_n`=1, `reg_off`=0, `acc_code`=0, `lane_mask`=0, `acc_err`=1 and `dreg_sel`=0.
- R3: `ldev_n` is 0 only when the captured `bus_dma` is 0 and the captured address bits [15:4] equal the base register. It is formed combinationally from the captured state and the current base, so a base write takes effect without a new strobe.
- R4: The base register is 12 bits wide and resets to 0. While `base_we`=1, it loads `base_wdata` on the rising edge of `clk`.
- R5: Code values: 1 is a full 32-bit access (byte enables 4'b0000, mask 4'b1111). 2 is the lower half (4'b1100, mask 4'b0011). 3 is the upper half (4'b0011, mask 4'b1100). The byte-enable vector is written with bit 3 on the left, and mask bit i stands for data lane D[8i+7:8i].
- R6: When exactly one byte enable is low, the code is 4 plus the lane number (4 to 7), and the mask has only that lane's bit set.
- R7: Any other byte-enable pattern, including 4'b1111, gives code 0, an all-zero mask and `acc_err`=1. Every valid pattern gives `acc_err`=0.
- R8: When `wide_mode` was 0 at capture, byte enables 3 and 2 are treated as high. A captured 4'b0000 then decodes as the lower half, and a pattern whose only low enable is 2 or 3 is invalid.
- R9: When the captured mode is wide and `dreg_cs_n` is 0, the byte enables are ignored: the code is 1, the mask is 4'b1111 and `dreg_sel`=1. This input acts combinationally. When the captured mode is narrow, it has no effect and `dreg_sel` stays 0.
- R10: `reg_off` equals the captured address bits [3:1] while `ldev_n`=0, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_we | input | 1 | Base register write strobe |
| base_wdata | input | 12 | Base register write data |
| bus_stb | input | 1 | Bus address strobe; rising edge captures |
| bus_addr | input | 15 | Bus address bits [15:1] |
| bus_dma | input | 1 | High marks a DMA cycle; decode only when low |
| bus_be_n | input | 4 | Active-low byte enables, bit i for lane i |
| dreg_cs_n | input | 1 | Active-low central data-register select |
| wide_mode | input | 1 | 1 selects the 32-bit bus, 0 the 16-bit bus |
| ldev_n | output | 1 | Active-low local device select |
| reg_off | output | 3 | Register offset within the decoded window |
| acc_code | output | 3 | Access kind code |
| lane_mask | output | 4 | Enabled data lanes |
| acc_err | output | 1 | Byte-enable pattern is invalid |
| dreg_sel | output | 1 | Central data-register access in force |

## Verification
The assertions take for granted that the bus address, qualifier, byte enables and mode are steady around the clock edge that sees the strobe rise. They also assume that the strobe stays low for at least one clock between captures, so that every rise is seen as an edge. The stimulus changes these inputs only at falling clock edges, and it holds the strobe high for exactly one rising edge. The central chip select and the base register are held constant while a result is pending, and each is changed only between checks.

// File: rtl/hb_dec_pkg.sv
package hb_dec_pkg;

  typedef enum logic [2:0] {
    ACC_BAD  = 3'd0,
    ACC_W32  = 3'd1,
    ACC_LO16 = 3'd2,
    ACC_HI16 = 3'd3,
    ACC_B0   = 3'd4,
    ACC_B1   = 3'd5,
    ACC_B2   = 3'd6,
    ACC_B3   = 3'd7
  } acc_e;

  // Active-low enables, bit i = lane i.
  function automatic acc_e classify(input logic [3:0] be_n);
    acc_e k;
    case (be_n)
      4'b0000: k = ACC_W32;
      4'b1100: k = ACC_LO16;
      4'b0011: k = ACC_HI16;
      4'b1110: k = ACC_B0;
      4'b1101: k = ACC_B1;
      4'b1011: k = ACC_B2;
      4'b0111: k = ACC_B3;
      default: k = ACC_BAD;
    endcase
    return k;
  endfunction

  function automatic logic [3:0] lanes_of(input acc_e k);
    logic [3:0] m;
    case (k)
      ACC_W32:  m = 4'b1111;
      ACC_LO16: m = 4'b0011;
      ACC_HI16: m = 4'b1100;
      ACC_B0:   m = 4'b0001;
      ACC_B1:   m = 4'b0010;
      ACC_B2:   m = 4'b0100;
      ACC_B3:   m = 4'b1000;
      default:  m = 4'b0000;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/hb_base_reg.sv
module hb_base_reg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] base
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  base <= '0;
    else if (we) base <= wdata;
  end

  assert_base_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> base == $past(wdata));
  assert_base_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(base));

endmodule

// File: rtl/hb_strobe_latch.sv
module hb_strobe_latch #(
  parameter int ADDR_W = 16,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic [ADDR_W-1:1] addr,
  input  logic              dma,
  input  logic [LANES-1:0]  be_n,
  input  logic              wide,
  output logic [ADDR_W-1:1] addr_q,
  output logic              dma_q,
  output logic [LANES-1:0]  be_q,
  output logic              wide_q
);

  logic stb_d;
  logic cap;

  // Starts high so a strobe already high at reset release is not an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_d <= 1'b1;
    else        stb_d <= stb;
  end

  assign cap = stb & ~stb_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      dma_q  <= 1'b1;
      be_q   <= '1;
      wide_q <= 1'b0;
    end else if (cap) begin
      addr_q <= addr;
      dma_q  <= dma;
      be_q   <= be_n;
      wide_q <= wide;
    end
  end

  assert_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !stb_d) |=> (addr_q == $past(addr)) && (be_q == $past(be_n))
                         && (dma_q == $past(dma)));
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb && !stb_d) |=> $stable(addr_q) && $stable(be_q) && $stable(dma_q)
                         && $stable(wide_q));

endmodule

// File: rtl/hb_base_match.sv
module hb_base_match #(
  parameter int ADDR_W   = 16,
  parameter int BASE_LSB = 4,
  localparam int BASE_W  = ADDR_W - BASE_LSB,
  localparam int OFF_W   = BASE_LSB - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:1] addr_q,
  input  logic              dma_q,
  input  logic [BASE_W-1:0] base,
  output logic              ldev_n,
  output logic [OFF_W-1:0]  off
);

  logic hit;

  assign hit    = (addr_q[ADDR_W-1:BASE_LSB] == base);
  assign ldev_n = ~(hit & ~dma_q);
  assign off    = ldev_n ? '0 : addr_q[BASE_LSB-1:1];

  assert_dma_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dma_q |-> ldev_n);
  assert_off_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ldev_n |-> off == '0);

endmodule

// File: rtl/hb_lane_decode.sv
module hb_lane_decode
  import hb_dec_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int NARROW_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] be_q,
  input  logic             wide_q,
  input  logic             cs_n,
  output logic [2:0]       code,
  output logic [LANES-1:0] mask,
  output logic             err,
  output logic             dsel
);

  logic [LANES-1:0] be_eff;
  acc_e             kind;

  // Lanes above the narrow width read as inactive in 16-bit mode.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    if (i < NARROW_N) begin : g_lo
      assign be_eff[i] = be_q[i];
    end else begin : g_hi
      assign be_eff[i] = be_q[i] | ~wide_q;
    end
  end

  assign dsel = wide_q & ~cs_n;
  assign kind = dsel ? ACC_W32 : classify(be_eff);
  assign code = kind;
  assign mask = lanes_of(kind);
  assign err  = (kind == ACC_BAD);

  assert_bad_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> mask == '0);
  assert_good_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !err |-> mask != '0);
  assert_byte_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    code[2] |-> $countones(mask) == 1);
  assert_narrow_lanes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_q |-> (mask[LANES-1:NARROW_N] == '0) && !dsel);
  assert_cs_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dsel |-> mask == '1 && !err);

endmodule

// File: rtl/hb_addr_decode.sv
module hb_addr_decode #(
  parameter int ADDR_W   = 16,
  parameter int BASE_LSB = 4,
  parameter int LANES    = 4,
  localparam int BASE_W  = ADDR_W - BASE_LSB,
  localparam int OFF_W   = BASE_LSB - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_we,
  input  logic [BASE_W-1:0] base_wdata,
  input  logic              bus_stb,
  input  logic [ADDR_W-1:1] bus_addr,
  input  logic              bus_dma,
  input  logic [LANES-1:0]  bus_be_n,
  input  logic              dreg_cs_n,
  input  logic              wide_mode,
  output logic              ldev_n,
  output logic [OFF_W-1:0]  reg_off,
  output logic [2:0]        acc_code,
  output logic [LANES-1:0]  lane_mask,
  output logic              acc_err,
  output logic              dreg_sel
);

  logic [BASE_W-1:0] base;
  logic [ADDR_W-1:1] addr_q;
  logic              dma_q;
  logic [LANES-1:0]  be_q;
  logic              wide_q;

  hb_base_reg #(.W(BASE_W)) u_base (
    .clk(clk), .rst_n(rst_n), .we(base_we), .wdata(base_wdata), .base(base)
  );

  hb_strobe_latch #(.ADDR_W(ADDR_W), .LANES(LANES)) u_latch (
    .clk(clk), .rst_n(rst_n), .stb(bus_stb), .addr(bus_addr), .dma(bus_dma),
    .be_n(bus_be_n), .wide(wide_mode), .addr_q(addr_q), .dma_q(dma_q),
    .be_q(be_q), .wide_q(wide_q)
  );

  hb_base_match #(.ADDR_W(ADDR_W), .BASE_LSB(BASE_LSB)) u_match (
    .clk(clk), .rst_n(rst_n), .addr_q(addr_q), .dma_q(dma_q), .base(base),
    .ldev_n(ldev_n), .off(reg_off)
  );

  hb_lane_decode #(.LANES(LANES), .NARROW_N(LANES / 2)) u_lanes (
    .clk(clk), .rst_n(rst_n), .be_q(be_q), .wide_q(wide_q), .cs_n(dreg_cs_n),
    .code(acc_code), .mask(lane_mask), .err(acc_err), .dsel(dreg_sel)
  );

endmodule

// File: tb/sim_hb_addr_decode.sv
`timescale 1ns/1ps
module sim_hb_addr_decode;

  typedef struct {
    logic       ldev_n;
    logic [2:0] off;
    logic [2:0] code;
    logic [3:0] mask;
    logic       err;
    logic       dsel;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_we = 1'b0;
  logic [11:0] base_wdata = '0;
  logic        bus_stb = 1'b0;
  logic [15:1] bus_addr = '0;
  logic        bus_dma = 1'b1;
  logic [3:0]  bus_be_n = 4'hF;
  logic        dreg_cs_n = 1'b1;
  logic        wide_mode = 1'b1;
  logic        ldev_n;
  logic [2:0]  reg_off;
  logic [2:0]  acc_code;
  logic [3:0]  lane_mask;
  logic        acc_err;
  logic        dreg_sel;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  exp_t sb[$];

  // Bench-side image of what was captured
  logic [15:0] l_addr = '0;
  logic        l_dma = 1'b1;
  logic [3:0]  l_be = 4'hF;
  logic        l_wide = 1'b0;
  logic [11:0] cur_base = '0;

  always #2 clk = ~clk;

  hb_addr_decode u0 (
    .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
    .bus_stb(bus_stb), .bus_addr(bus_addr), .bus_dma(bus_dma),
    .bus_be_n(bus_be_n), .dreg_cs_n(dreg_cs_n), .wide_mode(wide_mode),
    .ldev_n(ldev_n), .reg_off(reg_off), .acc_code(acc_code),
    .lane_mask(lane_mask), .acc_err(acc_err), .dreg_sel(dreg_sel)
  );

  function automatic exp_t model(string tag);
    exp_t e;
    logic [3:0] b;
    int lows;
    e.tag = tag;
    e.ldev_n = !(!l_dma && (l_addr[15:4] == cur_base));
    e.off = e.ldev_n ? 3'd0 : l_addr[3:1];
    e.dsel = l_wide && !dreg_cs_n;
    b = l_wide ? l_be : {2'b11, l_be[1:0]};
    lows = 0;
    for (int i = 0; i < 4; i++) if (!b[i]) lows++;
    e.code = 3'd0;
    e.mask = 4'b0000;
    if (e.dsel || b == 4'b0000) begin e.code = 3'd1; e.mask = 4'b1111; end
    else if (b == 4'b1100) begin e.code = 3'd2; e.mask = 4'b0011; end
    else if (b == 4'b0011) begin e.code = 3'd3; e.mask = 4'b1100; end
    else if (lows == 1) begin
      for (int i = 0; i < 4; i++)
        if (!b[i]) begin e.code = 3'(4 + i); e.mask = 4'(1 << i); end
    end
    e.err = (e.code == 3'd0);
    return e;
  endfunction

  // Monitor: compare one pending item at each falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (ldev_n !== e.ldev_n || reg_off !== e.off || acc_code !== e.code ||
            lane_mask !== e.mask || acc_err !== e.err || dreg_sel !== e.dsel) begin
          fails++;
          $display("FAIL %s: got ldev_n=%b off=%0d code=%0d mask=%b err=%b dsel=%b exp ldev_n=%b off=%0d code=%0d mask=%b err=%b dsel=%b",
                   e.tag, ldev_n, reg_off, acc_code, lane_mask, acc_err, dreg_sel,
                   e.ldev_n, e.off, e.code, e.mask, e.err, e.dsel);
        end
      end
    end
  end

  task automatic strobe(input logic [15:0] a, input logic dma, input logic [3:0] be,
                        input logic wide, input logic cs_n, input string tag);
    @(negedge clk);
    bus_addr = a[15:1]; bus_dma = dma; bus_be_n = be; wide_mode = wide;
    dreg_cs_n = cs_n; bus_stb = 1'b1;
    @(posedge clk);
    l_addr = {a[15:1], 1'b0}; l_dma = dma; l_be = be; l_wide = wide;
    sb.push_back(model(tag));
    @(negedge clk);
    bus_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic wiggle(input logic [15:0] a, input logic dma, input logic [3:0] be,
                        input string tag);
    @(negedge clk);
    bus_addr = a[15:1]; bus_dma = dma; bus_be_n = be; wide_mode = ~wide_mode;
    @(posedge clk);
    sb.push_back(model(tag));
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic set_base(input logic [11:0] v);
    @(negedge clk);
    base_we = 1'b1; base_wdata = v;
    @(negedge clk);
    base_we = 1'b0;
    cur_base = v;
  endtask

  task automatic reset_state(input string tag);
    l_addr = '0; l_dma = 1'b1; l_be = 4'hF; l_wide = 1'b0; cur_base = '0;
    sb.push_back(model(tag));
  endtask

  initial begin
    #4000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    reset_state("R2 reset state");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R4: base resets to zero, so window 0 decodes
    strobe(16'h000A, 0, 4'b0000, 1, 1, "R4 base reset / R5 full / R10 offset");
    set_base(12'h123);
    strobe(16'h1236, 0, 4'b1100, 1, 1, "R3 hit / R5 lower half");
    strobe(16'h1236, 1, 4'b1100, 1, 1, "R3 dma blocks");
    strobe(16'h1240, 0, 4'b1100, 1, 1, "R3 miss / R10 off zero");
    strobe(16'h123E, 0, 4'b0011, 1, 1, "R5 upper half");
    strobe(16'h1232, 0, 4'b1110, 1, 1, "R6 lane0");
    strobe(16'h1234, 0, 4'b1101, 1, 1, "R6 lane1");
    strobe(16'h1238, 0, 4'b1011, 1, 1, "R6 lane2");
    strobe(16'h123C, 0, 4'b0111, 1, 1, "R6 lane3");
    strobe(16'h1230, 0, 4'b1010, 1, 1, "R7 split pattern");
    strobe(16'h1230, 0, 4'b1111, 1, 1, "R7 none enabled");
    strobe(16'h1230, 0, 4'b1001, 1, 1, "R7 middle pair");
    strobe(16'h1232, 0, 4'b0000, 0, 1, "R8 narrow full -> lower half");
    strobe(16'h1232, 0, 4'b0111, 0, 1, "R8 narrow lane3 invalid");
    strobe(16'h1232, 0, 4'b1101, 0, 1, "R8 narrow lane1");
    strobe(16'h1234, 0, 4'b1010, 1, 0, "R9 central select overrides");
    strobe(16'h1234, 0, 4'b1110, 0, 0, "R9 ignored in narrow");
    strobe(16'h1236, 0, 4'b0011, 1, 1, "R1 new capture");
    wiggle(16'h0F00, 1, 4'b1010, "R2 hold without strobe");
    set_base(12'h0F0);
    sb.push_back(model("R3 base change live"));
    @(negedge clk); @(negedge clk);
    set_base(12'h123);
    sb.push_back(model("R3 base restore live"));
    @(negedge clk); @(negedge clk);
    strobe(16'h123A, 0, 4'b0000, 1, 1, "R1 capture before reset");
    @(negedge clk);
    rst_n = 1'b0;
    reset_state("R2 async reset clears");
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule